// File: doc/BRIEF.md
# Bit-Serial Programmable Logic Cell

This block is the logic part of one fine-grain cell in a bit-serial array. Each bit slot brings two multi-level inputs of two bits each. The operand level carries the current sum of two binary operands, A+B. The second level carries a binary operand C. A start-of-word marker is added on top of C as an extra value of two. Two threshold stages turn these levels into the binary variables m and n. A binary module then combines m and n into one serial result bit.

The threshold stages can be programmed. The operand decode is either plain (m is set when the level is at least 1) or AND-type (m is set when the level is at least 2, so m = A AND B). The AND-type decode serves multiplication partial products. The C decode is either plain or inverting; the inverting form turns a subtrahend into its complement for subtraction. The binary module has two modes. It can evaluate any of the 16 two-variable functions, chosen by a 4-bit function index. It can also act as a serial full adder whose carry is stored from one slot to the next. The start marker reloads that carry at the head of every word.

Words travel least-significant bit first. The threshold stage captures on the falling clock edge and the binary module stores on the rising edge, so each result bit appears one full clock after its inputs. All configuration inputs are static while a word is in flight.

Top module: `serial_logic_cell`

## Requirements
- R1: While reset is asserted (rst_n low), and on release before any slot is processed, res_o is 0 and the stored carry is 0.
- R2: Inputs presented in the clock cycle that begins at rising edge t are captured on the falling edge inside that cycle. Their result appears on res_o after rising edge t+1 and holds for one cycle, which gives one result bit per clock.
- R3: With cfg_and_i = 0 the operand variable is m = 1 for operand levels 1, 2 and 3, and m = 0 for level 0.
- R4: With cfg_and_i = 1 the operand variable is m = 1 only for operand levels 2 and 3. Levels 0 and 1 give m = 0, so A+B yields A AND B.
- R5: On the second input, bit 0 of the level is the data bit C. A level of 2 or more (threshold 1.5) marks the start of a word. Level 2 means start with C = 0 and level 3 means start with C = 1.
- R6: With cfg_inv_i = 1 the second variable is n = NOT C, and with cfg_inv_i = 0 it is n = C.
- R7: With cfg_add_i = 0 the result is bit (2*m + n) of cfg_func_i. For example, index 8 gives m AND n, 6 gives XOR and 14 gives OR.
- R8: With cfg_add_i = 1 the result is m XOR n XOR carry. The carry out, which is the majority of the three, is stored for the next slot, so an 8-bit word yields the sum of the two operands modulo 256.
- R9: In add mode, a slot that carries the start marker uses a carry-in equal to cfg_inv_i and ignores the stored carry. A word sent with the inverting decode therefore yields the difference of the operands modulo 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; threshold stage on falling edge, binary module on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ab_lvl_i | input | 2 | Operand level A+B, 0 to 3 |
| cs_lvl_i | input | 2 | Second level: bit 0 is C, value 2 or more marks start of word |
| cfg_and_i | input | 1 | 1 selects AND-type operand decode |
| cfg_inv_i | input | 1 | 1 inverts C and makes start load carry 1 |
| cfg_add_i | input | 1 | 1 selects serial full-adder sum, 0 selects function table |
| cfg_func_i | input | 4 | Two-variable function index |
| res_o | output | 1 | Serial result bit |

## Verification
Some checks run on every clock edge: the decode of each captured slot against the level driven one half-cycle earlier, the carry staying put in function mode, the carry following two equal operands, and the carry loading the mode-dependent value when a start marker meets unequal operands. Whole-word arithmetic can only be seen in the bench scenarios. These include 8-bit sums, differences and AND-mode partial-product sums checked against integer results, all sixteen function codes, and a start marker that clears a carry left pending by the previous word.

// File: rtl/slc_pkg.sv
`timescale 1ns/1ps
package slc_pkg;

  localparam int LVL_W     = 2;
  localparam int THR_LO    = 1;  // operand plain threshold (0.5)
  localparam int THR_HI    = 2;  // AND-type and start threshold (1.5)

  typedef struct packed {
    logic m;
    logic n;
    logic start;
  } slot_t;

  // function index -> stored programming bits {P1,P2,P3,P4}
  function automatic logic [3:0] idx_to_prog(input logic [3:0] k);
    return {k[3], ~k[2], ~k[1], k[0]};
  endfunction

  // evaluate programmed table; P2/P3 are kept in inverted form
  function automatic logic prog_eval(input logic [3:0] p, input logic m, input logic n);
    logic hi_half;
    logic lo_half;
    hi_half = n ? p[3] : ~p[2];
    lo_half = n ? ~p[1] : p[0];
    return m ? hi_half : lo_half;
  endfunction

  function automatic logic add_bit(input logic a, input logic b, input logic ci);
    return a ^ b ^ ci;
  endfunction

  function automatic logic add_carry(input logic a, input logic b, input logic ci);
    return (a & b) | (a & ci) | (b & ci);
  endfunction

endpackage

// File: rtl/slc_threshold.sv
`timescale 1ns/1ps
module slc_threshold
  import slc_pkg::*;
#(
  parameter int LW = LVL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] ab_lvl,
  input  logic [LW-1:0] cs_lvl,
  input  logic          cfg_and,
  input  logic          cfg_inv,
  output slot_t         slot_q
);

  localparam logic [LW-1:0] LO_T = LW'(THR_LO);
  localparam logic [LW-1:0] HI_T = LW'(THR_HI);

  logic  m_plain, m_and, c_bit, start_det;
  slot_t slot_d;

  assign m_plain   = (ab_lvl >= LO_T);
  assign m_and     = (ab_lvl >= HI_T);
  assign start_det = (cs_lvl >= HI_T);
  assign c_bit     = cs_lvl[0];

  always_comb begin
    slot_d.m     = cfg_and ? m_and : m_plain;
    slot_d.n     = c_bit ^ cfg_inv;
    slot_d.start = start_det;
  end

  // evaluate while clock high, hold while low
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= slot_d;
  end

  assert_and_decode_R4: assert property (@(negedge clk) disable iff (!rst_n)
    (cfg_and && ab_lvl < HI_T) |=> !slot_q.m);
  assert_plain_decode_R3: assert property (@(negedge clk) disable iff (!rst_n)
    (!cfg_and && ab_lvl != '0) |=> slot_q.m);
  assert_start_mark_R5: assert property (@(negedge clk) disable iff (!rst_n)
    (cs_lvl >= HI_T) |=> slot_q.start);
  assert_invert_R6: assert property (@(negedge clk) disable iff (!rst_n)
    (cfg_inv && !cs_lvl[0]) |=> slot_q.n);

endmodule

// File: rtl/slc_binary.sv
`timescale 1ns/1ps
module slc_binary
  import slc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  slot_t      slot_q,
  input  logic       cfg_add,
  input  logic       cfg_inv,
  input  logic [3:0] prog,
  output logic       res_q,
  output logic       carry_q
);

  logic carry_in, sum_bit, carry_nxt, fn_bit;

  assign carry_in  = slot_q.start ? cfg_inv : carry_q;
  assign sum_bit   = add_bit(slot_q.m, slot_q.n, carry_in);
  assign carry_nxt = add_carry(slot_q.m, slot_q.n, carry_in);
  assign fn_bit    = prog_eval(prog, slot_q.m, slot_q.n);

  // evaluate while clock low, store on rising edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= 1'b0;
      carry_q <= 1'b0;
    end else begin
      res_q <= cfg_add ? sum_bit : fn_bit;
      if (cfg_add) carry_q <= carry_nxt;
    end
  end

  assert_carry_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_add |=> $stable(carry_q));
  assert_carry_equal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_add && !slot_q.start && slot_q.m == slot_q.n) |=> carry_q == $past(slot_q.m));
  assert_start_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_add && slot_q.start && slot_q.m != slot_q.n) |=> carry_q == $past(cfg_inv));
  assert_start_sum_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_add && slot_q.start && !slot_q.m && !slot_q.n) |=> res_q == $past(cfg_inv));

endmodule

// File: rtl/serial_logic_cell.sv
`timescale 1ns/1ps
module serial_logic_cell
  import slc_pkg::*;
#(
  parameter int LW = LVL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] ab_lvl_i,
  input  logic [LW-1:0] cs_lvl_i,
  input  logic          cfg_and_i,
  input  logic          cfg_inv_i,
  input  logic          cfg_add_i,
  input  logic [3:0]    cfg_func_i,
  output logic          res_o
);

  slot_t      slot_q;
  logic [3:0] prog;
  logic       carry_q;

  assign prog = idx_to_prog(cfg_func_i);

  slc_threshold #(.LW(LW)) u_thr (
    .clk     (clk),
    .rst_n   (rst_n),
    .ab_lvl  (ab_lvl_i),
    .cs_lvl  (cs_lvl_i),
    .cfg_and (cfg_and_i),
    .cfg_inv (cfg_inv_i),
    .slot_q  (slot_q)
  );

  slc_binary u_bin (
    .clk     (clk),
    .rst_n   (rst_n),
    .slot_q  (slot_q),
    .cfg_add (cfg_add_i),
    .cfg_inv (cfg_inv_i),
    .prog    (prog),
    .res_q   (res_o),
    .carry_q (carry_q)
  );

  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |-> (res_o == 1'b0 && carry_q == 1'b0));

endmodule

// File: tb/serial_logic_cell_tb.sv
`timescale 1ns/1ps
module serial_logic_cell_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ab_lvl = '0;
  logic [1:0] cs_lvl = '0;
  logic       cfg_and = 1'b0, cfg_inv = 1'b0, cfg_add = 1'b0;
  logic [3:0] cfg_func = '0;
  logic       res_o;

  int errs = 0;
  int checks = 0;
  int ref_carry = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  serial_logic_cell u_dut (
    .clk(clk), .rst_n(rst_n), .ab_lvl_i(ab_lvl), .cs_lvl_i(cs_lvl),
    .cfg_and_i(cfg_and), .cfg_inv_i(cfg_inv), .cfg_add_i(cfg_add),
    .cfg_func_i(cfg_func), .res_o(res_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural model of one slot, returns expected result bit
  function automatic int model(input int ab, input int cs);
    int m, n, st, ci, tot, r;
    m  = cfg_and ? (ab >= 2) : (ab >= 1);
    st = (cs >= 2);
    n  = (cs % 2) ^ int'(cfg_inv);
    if (cfg_add) begin
      ci  = st ? int'(cfg_inv) : ref_carry;
      tot = m + n + ci;
      r   = tot % 2;
      ref_carry = tot / 2;
    end else begin
      r = (int'(cfg_func) >> (2 * m + n)) & 1;
    end
    return r;
  endfunction

  // one slot: drive now (just after a rising edge), check after the next rising edge (R2)
  task automatic slot(input int ab, input int cs, input string req, output int got);
    int e;
    ab_lvl = 2'(ab);
    cs_lvl = 2'(cs);
    e = model(ab, cs);
    @(posedge clk);
    #1;
    got = int'(res_o);
    chk(req, got, e);
  endtask

  task automatic word(input int xa, input int xb, input int y, input string req, output int w);
    int b;
    w = 0;
    for (int i = 0; i < 8; i++) begin
      slot(((xa >> i) & 1) + ((xb >> i) & 1), ((y >> i) & 1) + (i == 0 ? 2 : 0), req, b);
      w |= b << i;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      errs++;
      checks++;
      $display("FAIL watchdog: got 0 expected 1 (run completion)");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int got, w;
    int xs[6] = '{8'h00, 8'hFF, 8'h5A, 8'h81, 8'h7F, 8'h33};
    int ys[6] = '{8'h00, 8'h01, 8'hA5, 8'h81, 8'h01, 8'hCC};

    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset", int'(res_o), 0);
    rst_n = 1'b1;

    // R1: first add slot after reset with no marker uses stored carry 0
    cfg_add = 1'b1;
    slot(1, 1, "R1 carry after reset", got);
    slot(0, 0, "R8 carry from previous slot", got);

    // R7 / R3 / R5 / R6: every function code with every operand pair
    cfg_add = 1'b0;
    for (int k = 0; k < 16; k++) begin
      cfg_func = 4'(k);
      for (int mn = 0; mn < 4; mn++) slot(mn / 2, mn % 2, "R7 function", got);
      slot(2, 0, "R3 plain level 2", got);
      slot(3, 1, "R3 plain level 3", got);
      slot(0, 3, "R5 start level 3 carries C=1", got);
      slot(1, 2, "R5 start level 2 carries C=0", got);
      cfg_and = 1'b1;
      slot(1, 0, "R4 AND level 1", got);
      slot(2, 1, "R4 AND level 2", got);
      slot(3, 0, "R4 AND level 3", got);
      cfg_and = 1'b0;
      cfg_inv = 1'b1;
      slot(0, 0, "R6 invert C=0", got);
      slot(1, 1, "R6 invert C=1", got);
      cfg_inv = 1'b0;
    end

    // R8: serial add, word level against integer sum
    cfg_add = 1'b1;
    for (int i = 0; i < 6; i++) begin
      word(xs[i], 0, ys[i], "R8 add slot", w);
      chk("R8 add word", w, (xs[i] + ys[i]) % 256);
    end

    // R9: subtraction via inverting decode and start carry 1
    cfg_inv = 1'b1;
    for (int i = 0; i < 6; i++) begin
      word(xs[i], 0, ys[i], "R9 sub slot", w);
      chk("R9 sub word", w, (xs[i] - ys[i] + 256) % 256);
    end
    cfg_inv = 1'b0;

    // R9: start marker clears carry pending from previous word (0xFF+0x01 leaves carry 1)
    word(8'hFF, 0, 8'h01, "R9 pending carry slot", w);
    word(8'h00, 0, 8'h00, "R9 cleared carry slot", w);
    chk("R9 cleared carry word", w, 0);

    // R4: AND-type partial product accumulated with C
    cfg_and = 1'b1;
    for (int i = 0; i < 6; i++) begin
      word(xs[i], ys[(i + 2) % 6], ys[i], "R4 partial product slot", w);
      chk("R4 partial product word", w, ((xs[i] & ys[(i + 2) % 6]) + ys[i]) % 256);
    end
    // R3: same operands in plain mode sum as OR
    cfg_and = 1'b0;
    word(8'h5A, 8'h0F, 8'h01, "R3 plain OR slot", w);
    chk("R3 plain OR word", w, ((8'h5A | 8'h0F) + 1) % 256);

    // R2: one result per clock, held for the whole cycle
    cfg_add = 1'b0;
    cfg_func = 4'd6;
    slot(1, 0, "R2 latency", got);
    @(negedge clk);
    chk("R2 held mid-cycle", int'(res_o), 1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule